// File: doc/BRIEF.md
# Shared Multiply-Accumulate Datapath for Modular Arithmetic and Hashing

This block is the arithmetic core that a micro-code sequencer steers for multi-precision prime-field arithmetic and for bitwise hash rounds. Each cycle it takes two 16-bit words and a 4-bit opcode. It updates a 40-bit accumulator from a 16x16 product, from a plain 16-bit addend, from a bitwise logic result or from a single extracted bit. The words come from a dual-port memory outside the block.

For product-scanning multiplication, the sequencer issues multiply-accumulate steps for one word column. It reads the finished low word, then shifts the accumulator down by one word to start the next column. The 8 guard bits above the 32-bit product range hold the carries of many summed partial products. Hash rounds use the same register for AND, OR and XOR results, and scalar scanning uses it for single-bit extraction. Every result is seen on the two 16-bit output ports in the cycle after the operation is issued.

Top module: `mac_crypto_dp`

## Requirements
- R1: While `rst` is high at a clock edge the accumulator becomes zero, so `out_a_o` and `out_b_o` read 0 in the following cycle whatever the opcode.
- R2: Opcode 3 (multiply-accumulate) adds the 32-bit unsigned product `a_i*b_i` to the 40-bit accumulator, and the new value is on the outputs the cycle after issue.
- R3: The accumulator is 40 bits wide. 256 consecutive multiply-accumulates of 0xFFFF x 0xFFFF from zero give exactly 0xFF_FE00_0100 with no lost carry. Sums beyond 40 bits wrap modulo 2^40.
- R4: Opcode 2 (multiply-load) replaces the accumulator with the zero-extended product `a_i*b_i`.
- R5: Opcode 4 (add) adds the zero-extended `b_i` plus `cin_i` to the accumulator. `a_i` has no effect on it, and `cin_i` is ignored by every other opcode.
- R6: Opcode 5 (column shift) shifts the accumulator right by 16 bits and fills the top with zeros.
- R7: Opcode 6 (shift-and-multiply-accumulate) gives `(acc >> 16) + a_i*b_i` in one cycle.
- R8: Opcode 1 (clear) loads zero into the accumulator.
- R9: Opcodes 7, 8 and 9 load `a_i & b_i`, `a_i | b_i` and `a_i ^ b_i` into accumulator bits 15:0 and zero bits 39:16.
- R10: Opcode 10 (bit extract) loads `a_i[bit_sel_i]` into accumulator bit 0 and zeros bits 39:1.
- R11: Opcode 0 and the unused codes 11 to 15 leave the accumulator unchanged.
- R12: `out_a_o` shows accumulator bits 15:0 when `hi_sel_i` is 0 and bits 31:16 when it is 1 (a combinational select). `out_b_o` shows bits 39:32 in its low byte, and its high byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code from the sequencer |
| a_i | input | 16 | Operand word from memory port A |
| b_i | input | 16 | Operand word from memory port B |
| cin_i | input | 1 | Carry-in for the add operation |
| bit_sel_i | input | 4 | Bit index for bit extraction |
| hi_sel_i | input | 1 | Selects the upper or lower accumulator word on `out_a_o` |
| out_a_o | output | 16 | Selected 16-bit accumulator word |
| out_b_o | output | 16 | Accumulator guard byte, zero-extended |

## Verification
The accumulator is the only state, and both output ports show all 40 bits of it between them. A wrong accumulator value after any operation therefore reaches a port in the very next cycle. A dropped guard carry shows on `out_b_o` during the long multiply-accumulate runs. A wrong fill or shift distance shows on `out_a_o` with `hi_sel_i` high after a column shift. The bench changes `hi_sel_i` from step to step, so both 16-bit words are compared against an independent model after each operation.

// File: rtl/macdp_pkg.sv
package macdp_pkg;

    localparam int DP_WORD_W = 16;
    localparam int DP_ACC_W  = 40;
    localparam int DP_SEL_W  = $clog2(DP_WORD_W);

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_CLR  = 4'd1,
        OP_MUL  = 4'd2,
        OP_MAC  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SHR  = 4'd5,
        OP_SMAC = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_BIT  = 4'd10
    } mdp_op_e;

    typedef enum logic [1:0] {
        BASE_ACC   = 2'd0,
        BASE_SHIFT = 2'd1,
        BASE_ZERO  = 2'd2
    } base_sel_e;

    typedef enum logic [1:0] {
        ADDEND_NONE = 2'd0,
        ADDEND_PROD = 2'd1,
        ADDEND_OPB  = 2'd2
    } addend_sel_e;

    typedef struct packed {
        base_sel_e   base;
        addend_sel_e addend;
        logic        cin_en;
        logic        use_logic;
    } mdp_ctrl_t;

    function automatic mdp_ctrl_t mdp_decode(input logic [3:0] op);
        mdp_ctrl_t c;
        c.base      = BASE_ACC;
        c.addend    = ADDEND_NONE;
        c.cin_en    = 1'b0;
        c.use_logic = 1'b0;
        case (op)
            OP_CLR:  c.base = BASE_ZERO;
            OP_MUL:  begin c.base = BASE_ZERO;  c.addend = ADDEND_PROD; end
            OP_MAC:  c.addend = ADDEND_PROD;
            OP_ADD:  begin c.addend = ADDEND_OPB; c.cin_en = 1'b1; end
            OP_SHR:  c.base = BASE_SHIFT;
            OP_SMAC: begin c.base = BASE_SHIFT; c.addend = ADDEND_PROD; end
            OP_AND, OP_OR, OP_XOR, OP_BIT: c.use_logic = 1'b1;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mdp_mult.sv
module mdp_mult #(
    parameter int WORD_W = macdp_pkg::DP_WORD_W
) (
    input  logic [WORD_W-1:0]   a_i,
    input  logic [WORD_W-1:0]   b_i,
    output logic [2*WORD_W-1:0] prod_o
);
    localparam int PROD_W = 2 * WORD_W;

    always_comb begin
        prod_o = PROD_W'(a_i) * PROD_W'(b_i);
    end
endmodule

// File: rtl/mdp_logic.sv
module mdp_logic
    import macdp_pkg::*;
#(
    parameter int WORD_W = DP_WORD_W,
    localparam int SEL_W = $clog2(WORD_W)
) (
    input  logic [3:0]        op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [SEL_W-1:0]  bsel_i,
    output logic [WORD_W-1:0] res_o
);
    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_BIT:  res_o = {{(WORD_W-1){1'b0}}, a_i[bsel_i]};
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/mdp_accum.sv
module mdp_accum
    import macdp_pkg::*;
#(
    parameter int WORD_W = DP_WORD_W,
    parameter int ACC_W  = DP_ACC_W
) (
    input  logic [ACC_W-1:0]    acc_q_i,
    input  logic [2*WORD_W-1:0] prod_i,
    input  logic [WORD_W-1:0]   b_i,
    input  logic                cin_i,
    input  mdp_ctrl_t           ctrl_i,
    output logic [ACC_W-1:0]    acc_d_o
);
    localparam int PROD_W = 2 * WORD_W;

    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] sum1;

    always_comb begin
        case (ctrl_i.base)
            BASE_SHIFT: base = acc_q_i >> WORD_W;
            BASE_ZERO:  base = '0;
            default:    base = acc_q_i;
        endcase
    end

    always_comb begin
        case (ctrl_i.addend)
            ADDEND_PROD: addend = {{(ACC_W-PROD_W){1'b0}}, prod_i};
            ADDEND_OPB:  addend = {{(ACC_W-WORD_W){1'b0}}, b_i};
            default:     addend = '0;
        endcase
    end

    // first adder: base plus addend; second adder: carry-in
    always_comb begin
        sum1    = base + addend;
        acc_d_o = sum1 + {{(ACC_W-1){1'b0}}, cin_i & ctrl_i.cin_en};
    end
endmodule

// File: rtl/mac_crypto_dp.sv
module mac_crypto_dp
    import macdp_pkg::*;
#(
    parameter int WORD_W = DP_WORD_W,
    parameter int ACC_W  = DP_ACC_W,
    localparam int SEL_W   = $clog2(WORD_W),
    localparam int GUARD_W = ACC_W - 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              cin_i,
    input  logic [SEL_W-1:0]  bit_sel_i,
    input  logic              hi_sel_i,
    output logic [WORD_W-1:0] out_a_o,
    output logic [WORD_W-1:0] out_b_o
);
    mdp_ctrl_t             ctrl;
    logic [2*WORD_W-1:0]   prod;
    logic [WORD_W-1:0]     logic_res;
    logic [ACC_W-1:0]      arith_d;
    logic [ACC_W-1:0]      acc_d;
    logic [ACC_W-1:0]      acc_q;

    always_comb ctrl = mdp_decode(op_i);

    mdp_mult #(.WORD_W(WORD_W)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    mdp_logic #(.WORD_W(WORD_W)) u_logic (
        .op_i   (op_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .bsel_i (bit_sel_i),
        .res_o  (logic_res)
    );

    mdp_accum #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_accum (
        .acc_q_i (acc_q),
        .prod_i  (prod),
        .b_i     (b_i),
        .cin_i   (cin_i),
        .ctrl_i  (ctrl),
        .acc_d_o (arith_d)
    );

    always_comb begin
        if (ctrl.use_logic) acc_d = {{(ACC_W-WORD_W){1'b0}}, logic_res};
        else                acc_d = arith_d;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    always_comb begin
        out_a_o = hi_sel_i ? acc_q[2*WORD_W-1:WORD_W] : acc_q[WORD_W-1:0];
        out_b_o = {{(WORD_W-GUARD_W){1'b0}}, acc_q[ACC_W-1:2*WORD_W]};
    end
endmodule

// File: rtl/mdp_checker.sv
module mdp_checker
    import macdp_pkg::*;
#(
    parameter int WORD_W = DP_WORD_W,
    parameter int ACC_W  = DP_ACC_W
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_i,
    input logic [WORD_W-1:0] a_i,
    input logic [WORD_W-1:0] b_i,
    input logic [ACC_W-1:0]  acc_q,
    input logic [WORD_W-1:0] out_b_o
);
    localparam int GUARD_W = ACC_W - 2 * WORD_W;

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> acc_q == '0);

    p_mac_sum_r2: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_MAC |=> acc_q == $past(acc_q) + ACC_W'($past(a_i)) * ACC_W'($past(b_i)));

    p_shift_fill_r6: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_SHR |=> acc_q == ($past(acc_q) >> WORD_W));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_CLR |=> acc_q == '0);

    p_logic_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> acc_q[ACC_W-1:WORD_W] == '0);

    p_bit_only_r10: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_BIT |=> acc_q[ACC_W-1:1] == '0);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NOP || op_i > OP_BIT) |=> $stable(acc_q));

    p_guard_port_r12: assert property (@(posedge clk) disable iff (rst)
        out_b_o[WORD_W-1:GUARD_W] == '0);
endmodule

bind mac_crypto_dp mdp_checker #(.WORD_W(WORD_W), .ACC_W(ACC_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .acc_q   (acc_q),
    .out_b_o (out_b_o)
);

// File: tb/mac_crypto_dp_tb_top.sv
module mac_crypto_dp_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [15:0] a, b;
    logic        cin;
    logic [3:0]  bsel;
    logic        hsel;
    logic [15:0] out_a, out_b;

    int n_checks = 0;
    int n_fails  = 0;
    logic [39:0] model;

    always #5 clk = ~clk;

    mac_crypto_dp dut_i (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .a_i       (a),
        .b_i       (b),
        .cin_i     (cin),
        .bit_sel_i (bsel),
        .hi_sel_i  (hsel),
        .out_a_o   (out_a),
        .out_b_o   (out_b)
    );

    function automatic logic [39:0] ref_next(input logic [39:0] m, input logic [3:0] o,
                                             input logic [15:0] x, input logic [15:0] y,
                                             input logic c, input logic [3:0] s);
        longint unsigned v;
        v = longint'(m);
        case (o)
            4'd1:  v = 0;
            4'd2:  v = longint'(x) * longint'(y);
            4'd3:  v = v + longint'(x) * longint'(y);
            4'd4:  v = v + longint'(y) + longint'(c);
            4'd5:  v = v / 65536;
            4'd6:  v = v / 65536 + longint'(x) * longint'(y);
            4'd7:  v = longint'(x & y);
            4'd8:  v = longint'(x | y);
            4'd9:  v = longint'(x ^ y);
            4'd10: v = longint'(x[s]);
            default: ;
        endcase
        return v[39:0];
    endfunction

    task automatic compare(input string tag);
        logic [15:0] ea, eb;
        ea = hsel ? model[31:16] : model[15:0];
        eb = {8'h00, model[39:32]};
        n_checks++;
        if (out_a !== ea || out_b !== eb) begin
            n_fails++;
            $display("FAIL %s: out_a=%h out_b=%h expected out_a=%h out_b=%h",
                     tag, out_a, out_b, ea, eb);
        end
    endtask

    // called at a negedge: drive, let one edge pass, compare at the next negedge
    task automatic step(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                        input logic c, input logic [3:0] s, input logic h, input string tag);
        op = o; a = x; b = y; cin = c; bsel = s; hsel = h;
        model = ref_next(model, o, x, y, c, s);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; op = 4'd3; a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1; bsel = 0; hsel = 0;
        model = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset lo");
        hsel = 1'b1; #1;
        compare("R1 reset hi");
        rst = 1'b0;

        // R4 / R12 multiply-load and output select
        step(4'd2, 16'h1234, 16'h5678, 1'b1, 0, 1'b0, "R4 mul lo");
        step(4'd0, 16'h0, 16'h0, 1'b0, 0, 1'b1, "R12 hi word");
        // R2 accumulate
        step(4'd3, 16'hABCD, 16'h00FF, 1'b1, 0, 1'b0, "R2 mac");
        step(4'd3, 16'h8001, 16'h7FFF, 1'b0, 0, 1'b1, "R2 mac hi");
        // R11 hold on NOP and unused codes
        step(4'd0, 16'hFFFF, 16'hFFFF, 1'b1, 4'd3, 1'b0, "R11 nop");
        for (int k = 11; k < 16; k++) step(4'(k), 16'hFFFF, 16'hFFFF, 1'b1, 4'd7, 1'(k), "R11 unused");
        // R8 clear
        step(4'd1, 16'hFFFF, 16'hFFFF, 1'b1, 0, 1'b0, "R8 clr");
        // R3 long accumulation
        for (int k = 0; k < 256; k++) step(4'd3, 16'hFFFF, 16'hFFFF, 1'b0, 0, 1'(k), "R3 guard");
        n_checks++;
        if (model !== 40'hFF_FE00_0100 || out_b !== 16'h00FF) begin
            n_fails++;
            $display("FAIL R3: out_b=%h expected 00ff", out_b);
        end
        step(4'd3, 16'hFFFF, 16'hFFFF, 1'b0, 0, 1'b1, "R3 wrap");
        step(4'd3, 16'hFFFF, 16'hFFFF, 1'b0, 0, 1'b0, "R3 wrap");
        // R6 shift zero fill
        step(4'd5, 16'h0, 16'h0, 1'b1, 0, 1'b1, "R6 shr");
        step(4'd5, 16'h0, 16'h0, 1'b0, 0, 1'b0, "R6 shr");
        step(4'd5, 16'h0, 16'h0, 1'b0, 0, 1'b0, "R6 shr zero");
        // R5 add with carry, a ignored
        step(4'd4, 16'hDEAD, 16'hFFFF, 1'b1, 0, 1'b1, "R5 add cin");
        step(4'd4, 16'h1111, 16'hFFFF, 1'b0, 0, 1'b0, "R5 add nocin");
        step(4'd2, 16'hFFFF, 16'hFFFF, 1'b1, 0, 1'b0, "R5 cin ignored mul");
        // R7 shift-and-accumulate
        step(4'd6, 16'h4321, 16'h8765, 1'b1, 0, 1'b1, "R7 smac");
        step(4'd6, 16'hFFFF, 16'hFFFF, 1'b0, 0, 1'b0, "R7 smac");
        // R9 logic ops
        step(4'd7, 16'hF0F0, 16'h3C3C, 1'b1, 0, 1'b0, "R9 and");
        step(4'd0, 16'h0, 16'h0, 1'b0, 0, 1'b1, "R9 and upper");
        step(4'd8, 16'hF0F0, 16'h3C3C, 1'b0, 0, 1'b0, "R9 or");
        step(4'd9, 16'hF0F0, 16'h3C3C, 1'b0, 0, 1'b0, "R9 xor");
        // R10 bit extraction over all indices
        for (int k = 0; k < 16; k++) step(4'd10, 16'hA5C3, 16'hFFFF, 1'b1, 4'(k), 1'b0, "R10 bit");
        // mixed random patterns
        for (int k = 0; k < 400; k++)
            step(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom), 1'($urandom),
                 4'($urandom), 1'($urandom), "R2 mixed");
        // R1 reset mid-run
        op = 4'd3; a = 16'hFFFF; b = 16'hFFFF; rst = 1'b1; model = '0;
        @(negedge clk);
        compare("R1 reset again");
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule